// File: doc/BRIEF.md
# Single-Pin GPIO Cell with Interrupt Detection

This block is one general-purpose pin cell governed by a single 32-bit configuration word. Software writes the word through a plain synchronous port (`wrEn` with `wrData`), and `rdData` always shows the current state. The cell drives the pad controls (input enable, Schmitt trigger, drive strength, pull-up, pull-down, output enable) and the 5-bit alternate-function select unchanged from the stored fields. It produces the pin output value from one of four sources: a written value bit, write-only set/clear strobes, a DMA bit, or DMA bits applied as set/clear.

The cell also watches the pad input for interrupt events. Nine modes are available: edge and level modes run in a synchronous form through a two-flop synchronizer, and in an asynchronous form on the raw pad input. A sticky flag records each event. The flag can be cleared, and a mask gates the request output without stopping the flag from recording.

When a write and a DMA strobe arrive in the same cycle, the pin mode carried by that write decides how both are handled. In every other cycle the stored pin mode decides.

Top module: `gpin_cell`

## Requirements
- R1: After reset, `rdData` is 0, `irqOut` is 0, `padOut` is 0 and every pad control and `altSel` output is 0.
- R2: A write stores the input enable (bit 0), Schmitt (bit 1), drive (bits 3:2), pull-up (bit 4), pull-down (bit 5), output enable (bit 6), alternate select (bits 12:8), interrupt mode (bits 19:16), mask (bit 22) and pin mode (bits 31:30). The pad outputs show these fields from the next cycle on, and `rdData` returns them at the same positions.
- R3: Bits 20, 25 and 26 always read 0. Bit 21 reads the interrupt flag. Bit 24 reads the pin output value. Bit 28 reads the synchronized pad input when input enable is 1, and reads 0 when input enable is 0.
- R4: In pin mode 0, each write loads the pin output from bit 24, and the set and clear strobes in that write have no effect.
- R5: In pin mode 1, bit 25 sets the output and bit 26 clears it. When both are written together, the output is set. Bit 24 is ignored.
- R6: In pin mode 2, the output takes `dmaData` in each cycle that `dmaValid` is high. Register writes to bits 24, 25 and 26 do not change the output.
- R7: In pin mode 3, a valid DMA 1 sets the output and a valid DMA 0 clears it. Register set and clear strobes also act. Any set in a cycle beats any clear in that cycle.
- R8: Synchronous interrupt codes are 0 falling edge, 1 rising edge, 2 low level, 3 high level and 4 either edge. Each is judged on the two-flop synchronized input, so the flag rises on the third clock edge after the pad changes.
- R9: Asynchronous interrupt codes are 8 falling edge, 9 rising edge, 10 low level and 11 high level. Each is judged on the raw pad input, so the flag rises on the first clock edge after the pad changes.
- R10: Codes 5, 6, 7 and 12 through 15 never set the flag.
- R11: Writing bit 20 as 1 clears the flag, and the clear beats an event in the same cycle. When a level condition persists, the flag is set again one cycle later.
- R12: `irqOut` is the flag with the mask (bit 22) applied. While the mask is 1, `irqOut` stays 0 but the flag still records events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Configuration write strobe |
| wrData | input | 32 | Configuration write word |
| rdData | output | 32 | Current configuration and status word |
| padIn | input | 1 | Pad input level |
| dmaValid | input | 1 | DMA bit valid strobe |
| dmaData | input | 1 | DMA output bit |
| padInEn | output | 1 | Pad input enable |
| padSchmitt | output | 1 | Pad Schmitt trigger enable |
| padDrive | output | 2 | Pad drive strength |
| padPullUp | output | 1 | Pad pull-up enable |
| padPullDown | output | 1 | Pad pull-down enable |
| padOutEn | output | 1 | Pad output enable |
| padOut | output | 1 | Pin output value |
| altSel | output | 5 | Alternate-function select |
| irqOut | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same cycle. The first pair is a register strobe and a DMA strobe in set/clear mode: the bench writes a clear while a valid DMA 1 arrives, and writes a set while a valid DMA 0 arrives, then expects the output high after that edge in both cases. The second pair is a flag clear and a persisting level event: the bench writes the clear while the level is held, then expects `irqOut` low one cycle later and high again the cycle after.

// File: rtl/gpin_pkg.sv
package gpin_pkg;

  localparam int REG_W      = 32;
  localparam int DRIVE_W    = 2;
  localparam int ALT_W      = 5;
  localparam int IRQ_MODE_W = 4;
  localparam int PMODE_W    = 2;

  // Field positions inside the configuration word.
  localparam int B_IN_EN    = 0;
  localparam int B_SCHMITT  = 1;
  localparam int B_DRIVE    = 2;
  localparam int B_PULL_UP  = 4;
  localparam int B_PULL_DN  = 5;
  localparam int B_OUT_EN   = 6;
  localparam int B_ALT      = 8;
  localparam int B_IRQ_MODE = 16;
  localparam int B_IRQ_CLR  = 20;
  localparam int B_IRQ_FLAG = 21;
  localparam int B_IRQ_MASK = 22;
  localparam int B_OUT_VAL  = 24;
  localparam int B_OUT_SET  = 25;
  localparam int B_OUT_CLR  = 26;
  localparam int B_IN_VAL   = 28;
  localparam int B_PMODE    = 30;

  typedef enum logic [PMODE_W-1:0] {
    PM_DIRECT     = 2'd0,
    PM_SETCLR     = 2'd1,
    PM_DMA_DIRECT = 2'd2,
    PM_DMA_SETCLR = 2'd3
  } pinMode_t;

  typedef struct packed {
    logic                  inEn;
    logic                  schmitt;
    logic [DRIVE_W-1:0]    drive;
    logic                  pullUp;
    logic                  pullDn;
    logic                  outEn;
    logic [ALT_W-1:0]      alt;
    logic [IRQ_MODE_W-1:0] irqMode;
    logic                  irqMask;
    pinMode_t              pinMode;
  } pinCfg_t;

  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic loadCfg;
    logic loadVal;
    logic valData;
    logic irqClr;
    logic irqEvent;
  } pinStrobe_t;

endpackage

// File: rtl/gpin_ctrl.sv
module gpin_ctrl
  import gpin_pkg::*;
(
  input  logic                  wrEn,
  input  logic [REG_W-1:0]      wrData,
  input  pinMode_t              curMode,
  input  logic [IRQ_MODE_W-1:0] irqMode,
  input  logic                  dmaValid,
  input  logic                  dmaData,
  input  logic                  syncNow,
  input  logic                  syncLast,
  input  logic                  rawNow,
  input  logic                  rawLast,
  output pinCfg_t               newCfg,
  output pinStrobe_t            strobe
);

  pinMode_t                effMode;
  logic                    regSet, regClr, setReq, clrReq;
  logic                    isAsync, selNow, selLast, hit;
  logic [IRQ_MODE_W-2:0]   kind;
  logic                    unusedBits;

  assign unusedBits = ^{wrData[7], wrData[15:13], wrData[B_IRQ_FLAG], wrData[23], wrData[29:27]};

  // Decode of the written word into configuration fields.
  always_comb begin
    newCfg         = '0;
    newCfg.inEn    = wrData[B_IN_EN];
    newCfg.schmitt = wrData[B_SCHMITT];
    newCfg.drive   = wrData[B_DRIVE +: DRIVE_W];
    newCfg.pullUp  = wrData[B_PULL_UP];
    newCfg.pullDn  = wrData[B_PULL_DN];
    newCfg.outEn   = wrData[B_OUT_EN];
    newCfg.alt     = wrData[B_ALT +: ALT_W];
    newCfg.irqMode = wrData[B_IRQ_MODE +: IRQ_MODE_W];
    newCfg.irqMask = wrData[B_IRQ_MASK];
    newCfg.pinMode = pinMode_t'(wrData[B_PMODE +: PMODE_W]);
  end

  // Output source selection; the mode carried by a write governs its own cycle.
  always_comb begin
    effMode        = wrEn ? pinMode_t'(wrData[B_PMODE +: PMODE_W]) : curMode;
    regSet         = wrEn & wrData[B_OUT_SET];
    regClr         = wrEn & wrData[B_OUT_CLR];
    setReq         = 1'b0;
    clrReq         = 1'b0;
    strobe         = '0;
    strobe.loadCfg = wrEn;
    strobe.irqClr  = wrEn & wrData[B_IRQ_CLR];
    case (effMode)
      PM_DIRECT: begin
        strobe.loadVal = wrEn;
        strobe.valData = wrData[B_OUT_VAL];
      end
      PM_SETCLR: begin
        setReq = regSet;
        clrReq = regClr;
      end
      PM_DMA_DIRECT: begin
        strobe.loadVal = dmaValid;
        strobe.valData = dmaData;
      end
      default: begin
        setReq = regSet | (dmaValid & dmaData);
        clrReq = regClr | (dmaValid & ~dmaData);
      end
    endcase
    if (setReq || clrReq) begin
      strobe.loadVal = 1'b1;
      strobe.valData = setReq;   // set wins over clear
    end
    strobe.irqEvent = hit;
  end

  // Interrupt event detection from the stored mode.
  always_comb begin
    isAsync = irqMode[IRQ_MODE_W-1];
    kind    = irqMode[IRQ_MODE_W-2:0];
    selNow  = isAsync ? rawNow  : syncNow;
    selLast = isAsync ? rawLast : syncLast;
    case (kind)
      3'd0:    hit = selLast & ~selNow;
      3'd1:    hit = ~selLast & selNow;
      3'd2:    hit = ~selNow;
      3'd3:    hit = selNow;
      3'd4:    hit = ~isAsync & (selLast ^ selNow);
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/gpin_dp.sv
module gpin_dp
  import gpin_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  pinCfg_t    newCfg,
  input  pinStrobe_t strobe,
  input  logic       padIn,
  output pinCfg_t    cfg,
  output logic       outVal,
  output logic       irqFlag,
  output logic       syncNow,
  output logic       syncLast,
  output logic       rawLast
);

  logic [SYNC_STAGES-1:0] syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (strobe.loadCfg) begin
      cfg <= newCfg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outVal <= 1'b0;
    end else if (strobe.loadVal) begin
      outVal <= strobe.valData;
    end
  end

  // Sticky flag; a clear beats a same-cycle event.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
    end else if (strobe.irqClr) begin
      irqFlag <= 1'b0;
    end else if (strobe.irqEvent) begin
      irqFlag <= 1'b1;
    end
  end

  generate
    if (SYNC_STAGES == 1) begin : g_syncOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= padIn;
      end
    end else begin : g_syncChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], padIn};
      end
    end
  endgenerate

  assign syncNow = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncLast <= 1'b0;
      rawLast  <= 1'b0;
    end else begin
      syncLast <= syncNow;
      rawLast  <= padIn;
    end
  end

endmodule

// File: rtl/gpin_cell.sv
module gpin_cell
  import gpin_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  input  logic               padIn,
  input  logic               dmaValid,
  input  logic               dmaData,
  output logic               padInEn,
  output logic               padSchmitt,
  output logic [DRIVE_W-1:0] padDrive,
  output logic               padPullUp,
  output logic               padPullDown,
  output logic               padOutEn,
  output logic               padOut,
  output logic [ALT_W-1:0]   altSel,
  output logic               irqOut
);

  pinCfg_t    cfg, newCfg;
  pinStrobe_t strobe;
  logic       outVal, irqFlag, syncNow, syncLast, rawLast;

  gpin_ctrl u_ctrl (
    .wrEn     (wrEn),
    .wrData   (wrData),
    .curMode  (cfg.pinMode),
    .irqMode  (cfg.irqMode),
    .dmaValid (dmaValid),
    .dmaData  (dmaData),
    .syncNow  (syncNow),
    .syncLast (syncLast),
    .rawNow   (padIn),
    .rawLast  (rawLast),
    .newCfg   (newCfg),
    .strobe   (strobe)
  );

  gpin_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .newCfg   (newCfg),
    .strobe   (strobe),
    .padIn    (padIn),
    .cfg      (cfg),
    .outVal   (outVal),
    .irqFlag  (irqFlag),
    .syncNow  (syncNow),
    .syncLast (syncLast),
    .rawLast  (rawLast)
  );

  assign padInEn     = cfg.inEn;
  assign padSchmitt  = cfg.schmitt;
  assign padDrive    = cfg.drive;
  assign padPullUp   = cfg.pullUp;
  assign padPullDown = cfg.pullDn;
  assign padOutEn    = cfg.outEn;
  assign altSel      = cfg.alt;
  assign padOut      = outVal;
  assign irqOut      = irqFlag & ~cfg.irqMask;

  always_comb begin
    rdData                             = '0;
    rdData[B_IN_EN]                    = cfg.inEn;
    rdData[B_SCHMITT]                  = cfg.schmitt;
    rdData[B_DRIVE +: DRIVE_W]         = cfg.drive;
    rdData[B_PULL_UP]                  = cfg.pullUp;
    rdData[B_PULL_DN]                  = cfg.pullDn;
    rdData[B_OUT_EN]                   = cfg.outEn;
    rdData[B_ALT +: ALT_W]             = cfg.alt;
    rdData[B_IRQ_MODE +: IRQ_MODE_W]   = cfg.irqMode;
    rdData[B_IRQ_FLAG]                 = irqFlag;
    rdData[B_IRQ_MASK]                 = cfg.irqMask;
    rdData[B_OUT_VAL]                  = outVal;
    rdData[B_IN_VAL]                   = cfg.inEn & syncNow;
    rdData[B_PMODE +: PMODE_W]         = cfg.pinMode;
  end

endmodule

// File: rtl/gpin_cell_chk.sv
module gpin_cell_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic        dmaValid,
  input logic [31:0] rdData,
  input logic        padOut,
  input logic        irqOut
);

  logic unusedChk;
  assign unusedChk = ^{wrData, rdData};

  // R4: direct mode write loads the pin value
  a_r4_direct_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[31:30] == 2'd0) |=> (padOut == $past(wrData[24])));

  // R5 / R7: a register set in a set/clear mode always wins
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[30] && wrData[25]) |=> padOut);

  // R6: in DMA direct mode the output only moves on a DMA strobe
  a_r6_dma_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[31:30] == 2'd2 && !dmaValid && !(wrEn && wrData[31:30] != 2'd2)) |=> $stable(padOut));

  // R11: clear empties the flag on the next edge
  a_r11_clear: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[20]) |=> !rdData[21]);

  // R12: masked request stays low
  a_r12_mask: assert property (@(posedge clk) disable iff (!rstN)
    rdData[22] |-> !irqOut);

  // R10: the flag never rises under an unused code
  a_r10_unused: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdData[21]) |-> !($past(rdData[19:16]) inside {4'd5, 4'd6, 4'd7, 4'd12, 4'd13, 4'd14, 4'd15}));

endmodule

bind gpin_cell gpin_cell_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .dmaValid (dmaValid),
  .rdData   (rdData),
  .padOut   (padOut),
  .irqOut   (irqOut)
);

// File: tb/gpin_cell_bench.sv
module gpin_cell_bench;

  localparam int CLK_PERIOD = 10;

  localparam logic [31:0] CFG = 32'h0007_135B;
  localparam logic [31:0] M1  = 32'h4000_0000;
  localparam logic [31:0] M2  = 32'h8000_0000;
  localparam logic [31:0] M3  = 32'hC000_0000;
  localparam logic [31:0] VB  = 32'h0100_0000;
  localparam logic [31:0] SB  = 32'h0200_0000;
  localparam logic [31:0] CB  = 32'h0400_0000;
  localparam logic [31:0] CLR = 32'h0010_0000;
  localparam logic [31:0] MSK = 32'h0040_0000;
  localparam logic [31:0] IB  = 32'h0000_005B;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        padIn = 1'b0;
  logic        dmaValid = 1'b0;
  logic        dmaData = 1'b0;
  logic        padInEn, padSchmitt, padPullUp, padPullDown, padOutEn, padOut, irqOut;
  logic [1:0]  padDrive;
  logic [4:0]  altSel;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int          due;
    string       req;
    int          kind;
    logic [31:0] mask;
    logic [31:0] value;
  } sbItem_t;

  sbItem_t sb[$];

  gpin_cell u_gpin_cell (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .padIn(padIn), .dmaValid(dmaValid), .dmaData(dmaData),
    .padInEn(padInEn), .padSchmitt(padSchmitt), .padDrive(padDrive),
    .padPullUp(padPullUp), .padPullDown(padPullDown), .padOutEn(padOutEn),
    .padOut(padOut), .altSel(altSel), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  // kind: 0 rdData, 1 irqOut, 2 padOut, 3 pad control bundle
  function automatic logic [31:0] sample(int kind);
    case (kind)
      0:       return rdData;
      1:       return {31'b0, irqOut};
      2:       return {31'b0, padOut};
      default: return {20'b0, padInEn, padSchmitt, padDrive, padPullUp, padPullDown, padOutEn, altSel};
    endcase
  endfunction

  // Monitor: pops each expectation in its due cycle and compares.
  always @(negedge clk) begin
    sbItem_t it;
    logic [31:0] got;
    #1;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      it  = sb.pop_front();
      got = sample(it.kind) & it.mask;
      checks++;
      if (got !== (it.value & it.mask)) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, got, it.value & it.mask);
      end
    end
  end

  task automatic expectAt(int delay, string req, int kind, logic [31:0] mask, logic [31:0] value);
    sb.push_back('{cyc + delay, req, kind, mask, value});
  endtask

  task automatic drive(logic we, logic [31:0] d, logic dv, logic dd);
    wrEn = we; wrData = d; dmaValid = dv; dmaData = dd;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; dmaValid = 1'b0; dmaData = 1'b0;
  endtask

  task automatic wr(logic [31:0] d);
    drive(1'b1, d, 1'b0, 1'b0);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog req=all actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    // R1 reset state
    expectAt(0, "R1", 0, 32'hFFFF_FFFF, 32'h0);
    expectAt(0, "R1", 1, 32'h1, 32'h0);
    expectAt(0, "R1", 2, 32'h1, 32'h0);
    expectAt(0, "R1", 3, 32'hFFF, 32'h0);
    idle(1);

    // R2/R3/R4 configuration, write-only bits, direct value with strobes ignored
    expectAt(1, "R2", 3, 32'hFFF, 32'hEB3);
    expectAt(1, "R3", 0, 32'hD77F_1F7F, CFG | VB);
    expectAt(1, "R4", 2, 32'h1, 32'h1);
    wr(CFG | VB | SB | CB | CLR);
    expectAt(1, "R4", 2, 32'h1, 32'h0);
    wr(CFG | SB);

    // R3 input readback, R10 unused code 7
    padIn = 1'b1;
    expectAt(3, "R3", 0, 32'h1000_0000, 32'h1000_0000);
    expectAt(3, "R10", 1, 32'h1, 32'h0);
    idle(3);
    padIn = 1'b0;
    idle(3);

    // R5 set/clear mode
    expectAt(1, "R5", 2, 32'h1, 32'h1); wr(CFG | M1 | SB);
    expectAt(1, "R5", 2, 32'h1, 32'h0); wr(CFG | M1 | CB);
    expectAt(1, "R5", 2, 32'h1, 32'h1); wr(CFG | M1 | SB | CB);
    expectAt(1, "R5", 2, 32'h1, 32'h0); wr(CFG | M1 | CB);
    expectAt(1, "R5", 2, 32'h1, 32'h0); wr(CFG | M1 | VB);

    // R6 DMA direct
    expectAt(1, "R6", 2, 32'h1, 32'h0); wr(CFG | M2);
    expectAt(1, "R6", 2, 32'h1, 32'h1); drive(1'b0, '0, 1'b1, 1'b1);
    expectAt(1, "R6", 2, 32'h1, 32'h1); drive(1'b0, '0, 1'b0, 1'b0);
    expectAt(1, "R6", 2, 32'h1, 32'h1); wr(CFG | M2 | CB);
    expectAt(1, "R6", 2, 32'h1, 32'h0); drive(1'b1, CFG | M2 | VB, 1'b1, 1'b0);

    // R7 DMA set/clear, collisions
    expectAt(1, "R7", 2, 32'h1, 32'h0); wr(CFG | M3);
    expectAt(1, "R7", 2, 32'h1, 32'h1); drive(1'b0, '0, 1'b1, 1'b1);
    expectAt(1, "R7", 2, 32'h1, 32'h0); drive(1'b0, '0, 1'b1, 1'b0);
    expectAt(1, "R7", 2, 32'h1, 32'h1); drive(1'b1, CFG | M3 | CB, 1'b1, 1'b1);
    expectAt(1, "R7", 2, 32'h1, 32'h0); wr(CFG | M3 | CB);
    expectAt(1, "R7", 2, 32'h1, 32'h1); drive(1'b1, CFG | M3 | SB, 1'b1, 1'b0);

    // R8 synchronous rising, three-edge latency
    expectAt(1, "R8", 1, 32'h1, 32'h0); wr(IB | (32'd1 << 16) | CLR);
    padIn = 1'b1;
    expectAt(2, "R8", 1, 32'h1, 32'h0);
    expectAt(3, "R8", 1, 32'h1, 32'h1);
    idle(3);
    expectAt(1, "R11", 0, 32'h0020_0000, 32'h0); wr(IB | (32'd1 << 16) | CLR);
    // R8 synchronous falling
    wr(IB);
    padIn = 1'b0;
    expectAt(2, "R8", 1, 32'h1, 32'h0);
    expectAt(3, "R8", 1, 32'h1, 32'h1);
    idle(3);
    // R8 both edges
    expectAt(1, "R8", 1, 32'h1, 32'h0); wr(IB | (32'd4 << 16) | CLR);
    padIn = 1'b1;
    expectAt(3, "R8", 1, 32'h1, 32'h1);
    idle(3);
    expectAt(1, "R8", 1, 32'h1, 32'h0); wr(IB | (32'd4 << 16) | CLR);
    padIn = 1'b0;
    expectAt(3, "R8", 1, 32'h1, 32'h1);
    idle(3);
    // R8 high level, then R11 clear against persisting level
    expectAt(1, "R8", 1, 32'h1, 32'h0); wr(IB | (32'd3 << 16) | CLR);
    padIn = 1'b1;
    expectAt(3, "R8", 1, 32'h1, 32'h1);
    idle(3);
    expectAt(1, "R11", 1, 32'h1, 32'h0);
    expectAt(2, "R11", 1, 32'h1, 32'h1);
    wr(IB | (32'd3 << 16) | CLR);
    idle(1);
    // R8 low level
    expectAt(1, "R8", 1, 32'h1, 32'h0);
    expectAt(2, "R8", 1, 32'h1, 32'h0);
    wr(IB | (32'd2 << 16) | CLR);
    idle(1);
    padIn = 1'b0;
    expectAt(3, "R8", 1, 32'h1, 32'h1);
    idle(3);

    // R9 asynchronous modes, one-edge latency
    expectAt(1, "R9", 1, 32'h1, 32'h0);
    expectAt(2, "R9", 1, 32'h1, 32'h0);
    wr(IB | (32'd9 << 16) | CLR);
    idle(1);
    padIn = 1'b1;
    expectAt(1, "R9", 1, 32'h1, 32'h1); idle(1);
    expectAt(1, "R9", 1, 32'h1, 32'h0); wr(IB | (32'd8 << 16) | CLR);
    padIn = 1'b0;
    expectAt(1, "R9", 1, 32'h1, 32'h1); idle(1);
    expectAt(1, "R9", 1, 32'h1, 32'h0); wr(IB | (32'd11 << 16) | CLR);
    padIn = 1'b1;
    expectAt(1, "R9", 1, 32'h1, 32'h1); idle(1);
    expectAt(1, "R11", 1, 32'h1, 32'h0);
    expectAt(2, "R11", 1, 32'h1, 32'h1);
    wr(IB | (32'd11 << 16) | CLR);
    idle(1);
    expectAt(1, "R9", 1, 32'h1, 32'h0);
    expectAt(2, "R9", 1, 32'h1, 32'h0);
    wr(IB | (32'd10 << 16) | CLR);
    idle(1);
    padIn = 1'b0;
    expectAt(1, "R9", 1, 32'h1, 32'h1); idle(1);

    // R10 unused codes 12 and 5
    wr(IB | (32'd12 << 16) | CLR);
    padIn = 1'b1; idle(2);
    padIn = 1'b0; idle(2);
    expectAt(0, "R10", 1, 32'h1, 32'h0);
    expectAt(0, "R10", 0, 32'h0020_0000, 32'h0);
    wr(IB | (32'd5 << 16));
    padIn = 1'b1; idle(4);
    padIn = 1'b0; idle(4);
    expectAt(0, "R10", 0, 32'h0020_0000, 32'h0);

    // R12 mask keeps flag but blocks request
    wr(IB | (32'd3 << 16) | MSK | CLR);
    padIn = 1'b1;
    expectAt(3, "R12", 1, 32'h1, 32'h0);
    expectAt(3, "R12", 0, 32'h0020_0000, 32'h0020_0000);
    idle(3);
    expectAt(1, "R12", 1, 32'h1, 32'h1); wr(IB | (32'd3 << 16));

    // R3 input value reads 0 when input enable is off
    expectAt(1, "R3", 0, 32'h1000_0000, 32'h0);
    expectAt(1, "R2", 3, 32'h800, 32'h0);
    wr(32'h0000_005A);

    idle(4);
    done = 1;
    finishRun();
  end

endmodule